// File: doc/BRIEF.md
# Interleaved 4:2:2 Video Word Demultiplexer

This block takes progressive-scan YCbCr 4:2:2 video that arrives as one stream of words on a single bus and turns it back into pixels. Each pixel has a luma word, the chroma word it shares with its neighbour, and a flag that tells which chroma component it carries. The stream runs in pixel pairs, blue-difference chroma first, then the first luma, then red-difference chroma, then the second luma. Each line is framed by embedded timing references. A reference is a saturated word, two all-zero words and a status word. The status word carries field, vertical-blank and start/end-of-line flags and is guarded by parity bits.

The bus can be captured in two ways. In dual-edge mode a word arrives on each clock edge. At the block boundary this shows up as two words per clock: the rising-edge word, which comes first in time, and the falling-edge word. A configuration bit says which edge carries chroma words. Timing references are expected to start on that edge. In single-edge mode there is one word per rising edge, and both the falling-edge word and the edge-select bit are ignored. An 8-bit option uses only the upper eight bus bits and treats the two lowest as zero.

The parser is one state machine that steps once per word, so it steps twice per clock in dual-edge mode. Its states are `ST_HUNT` (searching), `ST_PRE1`, `ST_PRE2` and `ST_PRE3` (saturated word seen, then one zero, then two zeros), and the active states `ST_CB`, `ST_Y0`, `ST_CR` and `ST_Y1`. The transitions are as follows. HUNT goes to PRE1 on a saturated word in an allowed slot. PRE1 goes to PRE2 and PRE2 goes to PRE3 on a zero word, and either falls back to HUNT on any other word. PRE3 goes to CB on a valid start-of-line status word and back to HUNT on a valid end-of-line word or a bad one. The active states advance CB to Y0 to CR to Y1 and back to CB. Any active state goes to PRE1 on a saturated word.

Top module: `vid422_demux`

## Requirements
- R1: A synchronous active-high reset puts the parser into the searching state and clears every output to zero. After reset, no pixel is produced until a valid start-of-line reference has been decoded, even if pixel data arrives.
- R2: In dual-edge mode (cfg_dual_edge=1) the block takes two words per clock, the rising-edge word first and the falling-edge word second. A pixel appears on the outputs at the clock edge that samples its luma word.
- R3: With cfg_y_on_rise=0, chroma words are on the rising edge, and a reference can start only on the rising-edge word. With cfg_y_on_rise=1, luma words are on the rising edge, and a reference can start only on the falling-edge word. A saturated word in the other slot is ignored while searching.
- R4: In single-edge mode (cfg_dual_edge=0) the block takes one word per clock from word_rise. word_fall and cfg_y_on_rise have no effect.
- R5: A reference is the saturated word, then two zero words, then a status word. The status word's bit 8 is the field flag, bit 7 is vertical blank, and bit 6 is H (0 for start of line, 1 for end of line). A valid status word pulses ref_stb for one cycle and loads ref_field, ref_vblank and ref_eav.
- R6: A status word is valid only if bit 9 is 1 and bit 5 = V^H, bit 4 = F^H, bit 3 = F^V and bit 2 = F^V^H. An invalid status word pulses ref_err, leaves the three flags unchanged and does not start a line.
- R7: Pixels are produced only between a start-of-line reference and the next saturated word. Reference words never appear as pixel data.
- R8: One pixel comes out for every two active words. A blue-chroma word followed by a luma word gives a pixel with pix_is_cr=0. A red-chroma word followed by a luma word gives pix_is_cr=1. pix_c is the chroma word of that pair.
- R9: Every start-of-line reference restarts the component order at blue chroma, so a line with a missing or extra word does not disturb the line that follows.
- R10: With cfg_narrow=1, the two lowest bits of every word are forced to zero, and any word whose upper eight bits are all ones counts as saturated. With cfg_narrow=0, only 3FF is saturated, so 3FC does not start a reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual_edge | input | 1 | 1: two words per clock; 0: one word per clock |
| cfg_y_on_rise | input | 1 | Dual-edge phase: 1 when the rising-edge word is luma |
| cfg_narrow | input | 1 | 8-bit input on the upper bus bits |
| word_rise | input | 10 | Word captured on the rising edge |
| word_fall | input | 10 | Word captured on the falling edge (dual-edge only) |
| pix_valid | output | 1 | Pixel outputs hold a new pixel this cycle |
| pix_y | output | 10 | Luma of the pixel |
| pix_c | output | 10 | Chroma word shared by the pixel |
| pix_is_cr | output | 1 | 0: pix_c is blue chroma; 1: red chroma |
| ref_stb | output | 1 | One-cycle pulse on a valid status word |
| ref_err | output | 1 | One-cycle pulse on a status word failing its parity |
| ref_field | output | 1 | Field flag of the last valid status word |
| ref_vblank | output | 1 | Vertical-blank flag of the last valid status word |
| ref_eav | output | 1 | H flag of the last valid status word |

## Verification
A wrong parser state shows up at the ports within a few words. Pixels appear before any start-of-line reference, or with luma and chroma swapped, or with the wrong pix_is_cr. Pixels can also go missing, because a reference that started on the wrong slot never locks. A broken parity check either pulses ref_err for a good status word or changes the flags on a bad one, and this shows in the cycle after the status word. Recovery from a damaged line is checked by requiring exact pixels on the next line, starting from its first pixel.

// File: rtl/vid422_pkg.sv
package vid422_pkg;

    parameter int VW = 10;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_PRE1,
        ST_PRE2,
        ST_PRE3,
        ST_CB,
        ST_Y0,
        ST_CR,
        ST_Y1
    } parse_st_e;

endpackage

// File: rtl/vid422_capture.sv
module vid422_capture #(
    parameter int WORD_W = vid422_pkg::VW
) (
    input  logic              cfg_dual_edge,
    input  logic              cfg_y_on_rise,
    input  logic              cfg_narrow,
    input  logic [WORD_W-1:0] word_rise,
    input  logic [WORD_W-1:0] word_fall,
    output logic [WORD_W-1:0] w0,
    output logic [WORD_W-1:0] w1,
    output logic              two_words,
    output logic              start_ok0,
    output logic              start_ok1
);
    localparam int DROP = WORD_W - 8;
    localparam logic [WORD_W-1:0] KEEP_MASK = ~WORD_W'((1 << DROP) - 1);

    logic [WORD_W-1:0] rise_n;
    logic [WORD_W-1:0] fall_n;

    // 8-bit option: low bits are forced to zero
    always_comb begin
        rise_n = cfg_narrow ? (word_rise & KEEP_MASK) : word_rise;
        fall_n = cfg_narrow ? (word_fall & KEEP_MASK) : word_fall;
    end

    // Time order within a clock is always rising word first.
    // The edge-select bit only decides which slot may open a reference.
    always_comb begin
        if (cfg_dual_edge) begin
            w0        = rise_n;
            w1        = fall_n;
            two_words = 1'b1;
            start_ok0 = ~cfg_y_on_rise;
            start_ok1 = cfg_y_on_rise;
        end else begin
            w0        = rise_n;
            w1        = '0;
            two_words = 1'b0;
            start_ok0 = 1'b1;
            start_ok1 = 1'b0;
        end
    end

endmodule

// File: rtl/vid422_parser.sv
module vid422_parser
    import vid422_pkg::*;
#(
    parameter int WORD_W = vid422_pkg::VW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_narrow,
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    input  logic              two_words,
    input  logic              start_ok0,
    input  logic              start_ok1,
    output logic              pix_valid,
    output logic [WORD_W-1:0] pix_y,
    output logic [WORD_W-1:0] pix_c,
    output logic              pix_is_cr,
    output logic              ref_stb,
    output logic              ref_err,
    output logic              ref_field,
    output logic              ref_vblank,
    output logic              ref_eav
);
    localparam int DROP = WORD_W - 8;
    localparam int B_MK = WORD_W - 1;
    localparam int B_F  = WORD_W - 2;
    localparam int B_V  = WORD_W - 3;
    localparam int B_H  = WORD_W - 4;
    localparam int B_P3 = WORD_W - 5;
    localparam int B_P2 = WORD_W - 6;
    localparam int B_P1 = WORD_W - 7;
    localparam int B_P0 = WORD_W - 8;

    typedef struct packed {
        parse_st_e         st;
        logic [WORD_W-1:0] chroma;
        logic              emit;
        logic              emit_cr;
        logic [WORD_W-1:0] y;
        logic              good;
        logic              bad;
        logic              f;
        logic              v;
        logic              h;
    } step_t;

    parse_st_e         state;
    logic [WORD_W-1:0] chroma_q;
    step_t             s_a;
    step_t             s_b;
    step_t             s_fin;
    logic              emit;
    logic              emit_cr;
    logic [WORD_W-1:0] emit_y;
    logic [WORD_W-1:0] emit_c;
    logic              good;
    logic              bad;
    logic              fl_f;
    logic              fl_v;
    logic              fl_h;

    // One word through the parse state machine
    function automatic step_t step_word(parse_st_e st, logic [WORD_W-1:0] ch,
                                        logic [WORD_W-1:0] w, logic ok,
                                        logic narrow);
        step_t r;
        logic  sat;
        logic  zero;
        logic  par_ok;
        r        = '0;
        r.st     = st;
        r.chroma = ch;
        sat      = (&w[WORD_W-1:DROP]) && (narrow || (&w[DROP-1:0]));
        zero     = (w == '0);
        par_ok   = w[B_MK]
                 && (w[B_P3] == (w[B_V] ^ w[B_H]))
                 && (w[B_P2] == (w[B_F] ^ w[B_H]))
                 && (w[B_P1] == (w[B_F] ^ w[B_V]))
                 && (w[B_P0] == (w[B_F] ^ w[B_V] ^ w[B_H]));
        unique case (st)
            ST_HUNT: begin
                if (sat && ok) r.st = ST_PRE1;
            end
            ST_PRE1: r.st = zero ? ST_PRE2 : ST_HUNT;
            ST_PRE2: r.st = zero ? ST_PRE3 : ST_HUNT;
            ST_PRE3: begin
                if (par_ok) begin
                    r.good = 1'b1;
                    r.f    = w[B_F];
                    r.v    = w[B_V];
                    r.h    = w[B_H];
                    r.st   = w[B_H] ? ST_HUNT : ST_CB;
                end else begin
                    r.bad = 1'b1;
                    r.st  = ST_HUNT;
                end
            end
            ST_CB: begin
                if (sat) begin
                    r.st = ST_PRE1;
                end else begin
                    r.chroma = w;
                    r.st     = ST_Y0;
                end
            end
            ST_Y0: begin
                if (sat) begin
                    r.st = ST_PRE1;
                end else begin
                    r.emit    = 1'b1;
                    r.emit_cr = 1'b0;
                    r.y       = w;
                    r.st      = ST_CR;
                end
            end
            ST_CR: begin
                if (sat) begin
                    r.st = ST_PRE1;
                end else begin
                    r.chroma = w;
                    r.st     = ST_Y1;
                end
            end
            ST_Y1: begin
                if (sat) begin
                    r.st = ST_PRE1;
                end else begin
                    r.emit    = 1'b1;
                    r.emit_cr = 1'b1;
                    r.y       = w;
                    r.st      = ST_CB;
                end
            end
        endcase
        return r;
    endfunction

    // Chain one or two steps per clock
    always_comb begin
        s_a   = step_word(state, chroma_q, w0, start_ok0, cfg_narrow);
        s_b   = step_word(s_a.st, s_a.chroma, w1, start_ok1, cfg_narrow);
        s_fin = two_words ? s_b : s_a;
        if (s_a.emit) begin
            emit    = 1'b1;
            emit_cr = s_a.emit_cr;
            emit_y  = s_a.y;
            emit_c  = s_a.chroma;
        end else begin
            emit    = two_words && s_b.emit;
            emit_cr = s_b.emit_cr;
            emit_y  = s_b.y;
            emit_c  = s_b.chroma;
        end
        if (s_a.good || s_a.bad) begin
            good = s_a.good;
            bad  = s_a.bad;
            fl_f = s_a.f;
            fl_v = s_a.v;
            fl_h = s_a.h;
        end else begin
            good = two_words && s_b.good;
            bad  = two_words && s_b.bad;
            fl_f = s_b.f;
            fl_v = s_b.v;
            fl_h = s_b.h;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            chroma_q <= '0;
        end else begin
            state    <= s_fin.st;
            chroma_q <= s_fin.chroma;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid  <= 1'b0;
            pix_y      <= '0;
            pix_c      <= '0;
            pix_is_cr  <= 1'b0;
            ref_stb    <= 1'b0;
            ref_err    <= 1'b0;
            ref_field  <= 1'b0;
            ref_vblank <= 1'b0;
            ref_eav    <= 1'b0;
        end else begin
            pix_valid <= emit;
            ref_stb   <= good;
            ref_err   <= bad;
            if (emit) begin
                pix_y     <= emit_y;
                pix_c     <= emit_c;
                pix_is_cr <= emit_cr;
            end
            if (good) begin
                ref_field  <= fl_f;
                ref_vblank <= fl_v;
                ref_eav    <= fl_h;
            end
        end
    end

    // Checks next to the logic they guard
    logic rst_seen;
    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen) begin
            assert_reset_clear_R1: assert (!pix_valid && !ref_stb && !ref_err && state == ST_HUNT);
        end
    end

    assert_pix_only_active_R7: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> ($past(state) inside {ST_CB, ST_Y0, ST_CR, ST_Y1}));

    assert_bad_keeps_flags_R6: assert property (@(posedge clk) disable iff (rst)
        ref_err |-> $stable({ref_field, ref_vblank, ref_eav}));

    assert_no_pix_with_ref_R5: assert property (@(posedge clk) disable iff (rst)
        ref_stb |-> !pix_valid);

    assert_narrow_low_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(cfg_narrow)) |-> (pix_y[DROP-1:0] == '0));

endmodule

// File: rtl/vid422_demux.sv
module vid422_demux #(
    parameter int WORD_W = vid422_pkg::VW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_dual_edge,
    input  logic              cfg_y_on_rise,
    input  logic              cfg_narrow,
    input  logic [WORD_W-1:0] word_rise,
    input  logic [WORD_W-1:0] word_fall,
    output logic              pix_valid,
    output logic [WORD_W-1:0] pix_y,
    output logic [WORD_W-1:0] pix_c,
    output logic              pix_is_cr,
    output logic              ref_stb,
    output logic              ref_err,
    output logic              ref_field,
    output logic              ref_vblank,
    output logic              ref_eav
);
    logic [WORD_W-1:0] w0;
    logic [WORD_W-1:0] w1;
    logic              two_words;
    logic              start_ok0;
    logic              start_ok1;

    vid422_capture #(.WORD_W(WORD_W)) u_capture (
        .cfg_dual_edge(cfg_dual_edge),
        .cfg_y_on_rise(cfg_y_on_rise),
        .cfg_narrow   (cfg_narrow),
        .word_rise    (word_rise),
        .word_fall    (word_fall),
        .w0           (w0),
        .w1           (w1),
        .two_words    (two_words),
        .start_ok0    (start_ok0),
        .start_ok1    (start_ok1)
    );

    vid422_parser #(.WORD_W(WORD_W)) u_parser (
        .clk       (clk),
        .rst       (rst),
        .cfg_narrow(cfg_narrow),
        .w0        (w0),
        .w1        (w1),
        .two_words (two_words),
        .start_ok0 (start_ok0),
        .start_ok1 (start_ok1),
        .pix_valid (pix_valid),
        .pix_y     (pix_y),
        .pix_c     (pix_c),
        .pix_is_cr (pix_is_cr),
        .ref_stb   (ref_stb),
        .ref_err   (ref_err),
        .ref_field (ref_field),
        .ref_vblank(ref_vblank),
        .ref_eav   (ref_eav)
    );

endmodule

// File: tb/vid422_demux_bench.sv
`timescale 1ns/1ps
module vid422_demux_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_dual_edge = 1'b0;
    logic       cfg_y_on_rise = 1'b0;
    logic       cfg_narrow = 1'b0;
    logic [9:0] word_rise = '0;
    logic [9:0] word_fall = '0;
    logic       pix_valid, pix_is_cr, ref_stb, ref_err, ref_field, ref_vblank, ref_eav;
    logic [9:0] pix_y, pix_c;

    always #5 clk = ~clk;

    vid422_demux u_vid422_demux (
        .clk(clk), .rst(rst), .cfg_dual_edge(cfg_dual_edge), .cfg_y_on_rise(cfg_y_on_rise),
        .cfg_narrow(cfg_narrow), .word_rise(word_rise), .word_fall(word_fall),
        .pix_valid(pix_valid), .pix_y(pix_y), .pix_c(pix_c), .pix_is_cr(pix_is_cr),
        .ref_stb(ref_stb), .ref_err(ref_err), .ref_field(ref_field),
        .ref_vblank(ref_vblank), .ref_eav(ref_eav)
    );

    int total = 0;
    int bad = 0;

    logic [9:0] stm [0:63];
    int         n;
    logic [9:0] ey [0:31];
    logic [9:0] ec [0:31];
    logic       ecr [0:31];
    int         ne;
    logic [9:0] ly [0:31];
    logic [9:0] lc [0:31];
    logic       lcr [0:31];
    int         nl;
    logic       lh [0:15];
    int         nr;
    int         nerr;

    // Output log, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (pix_valid && nl < 32) begin
                ly[nl] = pix_y; lc[nl] = pix_c; lcr[nl] = pix_is_cr; nl++;
            end
            if (ref_stb && nr < 16) begin
                lh[nr] = ref_eav; nr++;
            end
            if (ref_err) nerr++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] mk_xy(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

    task automatic clear_all();
        n = 0; ne = 0; nl = 0; nr = 0; nerr = 0;
    endtask

    task automatic put(input logic [9:0] w);
        stm[n] = w; n++;
    endtask

    task automatic put_ref(input bit f, input bit v, input bit h);
        put(10'h3FF); put(10'h000); put(10'h000); put(mk_xy(f, v, h));
    endtask

    task automatic expect_pix(input logic [9:0] y, input logic [9:0] c, input logic cr);
        ey[ne] = y; ec[ne] = c; ecr[ne] = cr; ne++;
    endtask

    task automatic put_line(input int base, input int pairs);
        for (int i = 0; i < pairs; i++) begin
            logic [9:0] cb, cr, y0, y1;
            cb = 10'(10'h100 + base + i * 4);
            cr = 10'(10'h101 + base + i * 4);
            y0 = 10'(10'h040 + base + i * 4);
            y1 = 10'(10'h041 + base + i * 4);
            put(cb); put(y0); put(cr); put(y1);
            expect_pix(y0, cb, 1'b0);
            expect_pix(y1, cr, 1'b1);
        end
    endtask

    task automatic drive(input logic [9:0] r, input logic [9:0] f);
        @(posedge clk);
        #2;
        word_rise = r;
        word_fall = f;
    endtask

    task automatic play();
        nl = 0; nr = 0; nerr = 0;
        if (cfg_dual_edge) begin
            for (int i = 0; i < n; i += 2) drive(stm[i], stm[i + 1]);
        end else begin
            for (int i = 0; i < n; i++) drive(stm[i], 10'h3FF);
        end
        for (int i = 0; i < 4; i++) drive(10'h000, 10'h000);
    endtask

    task automatic compare_pixels(input string req);
        chk(nl == ne, {req, " pixel count"}, nl, ne);
        for (int i = 0; i < ne && i < nl; i++) begin
            chk(ly[i] == ey[i] && lc[i] == ec[i] && lcr[i] == ecr[i], req,
                {ly[i], lc[i], 3'b0, lcr[i]}, {ey[i], ec[i], 3'b0, ecr[i]});
        end
    endtask

    task automatic t_reset();
        // R1: outputs clear during reset, no pixel before a start-of-line reference
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!pix_valid && !ref_stb && !ref_err, "R1 reset outputs", {pix_valid, ref_stb, ref_err}, 0);
        chk(!ref_field && !ref_vblank && !ref_eav, "R1 reset flags", {ref_field, ref_vblank, ref_eav}, 0);
        rst = 1'b0;
        clear_all();
        cfg_dual_edge = 1'b0;
        put_line(0, 3);
        ne = 0;
        play();
        chk(nl == 0, "R1 no pixel before start reference", nl, 0);
    endtask

    task automatic t_dual_chroma_rise();
        // R2 R5 R7 R8: dual-edge, chroma on the rising word
        clear_all();
        cfg_dual_edge = 1'b1; cfg_y_on_rise = 1'b0;
        put_ref(1'b1, 1'b0, 1'b0);
        put_line(0, 3);
        put_ref(1'b1, 1'b0, 1'b1);
        play();
        compare_pixels("R2 R8 dual chroma-on-rise");
        chk(nr == 2, "R5 two references decoded", nr, 2);
        chk(nr == 2 && lh[0] == 1'b0 && lh[1] == 1'b1, "R7 start then end", {lh[0], lh[1]}, 1);
        chk(ref_field && !ref_vblank && ref_eav, "R5 flags held", {ref_field, ref_vblank, ref_eav}, 3'b101);
    endtask

    task automatic t_dual_luma_rise();
        // R3: luma on the rising word, reference opens on the falling word
        clear_all();
        cfg_dual_edge = 1'b1; cfg_y_on_rise = 1'b1;
        put(10'h155);
        put_ref(1'b0, 1'b1, 1'b0);
        put_line(8, 2);
        put_ref(1'b0, 1'b1, 1'b1);
        put(10'h000);
        play();
        compare_pixels("R3 dual luma-on-rise");
        chk(!ref_field && ref_vblank && ref_eav, "R5 vblank flag", {ref_field, ref_vblank, ref_eav}, 3'b011);
        // same stream, wrong phase: saturated word sits in a slot that may not open a reference
        cfg_y_on_rise = 1'b0;
        play();
        chk(nl == 0, "R3 wrong phase gives no pixels", nl, 0);
        chk(nr == 0, "R3 wrong phase gives no reference", nr, 0);
    endtask

    task automatic t_single();
        // R4: single-edge; falling word carries saturated garbage, edge bit set
        clear_all();
        cfg_dual_edge = 1'b0; cfg_y_on_rise = 1'b1;
        put_ref(1'b0, 1'b0, 1'b0);
        put_line(16, 2);
        put_ref(1'b0, 1'b0, 1'b1);
        play();
        compare_pixels("R4 single-edge ignores fall word");
        chk(nr == 2, "R4 references in single-edge", nr, 2);
    endtask

    task automatic t_parity();
        // R6: bad parity pulses error, keeps flags, does not start a line
        clear_all();
        cfg_dual_edge = 1'b0;
        put_ref(1'b1, 1'b1, 1'b1);
        put(10'h3FF); put(10'h000); put(10'h000); put(mk_xy(1'b0, 1'b0, 1'b0) ^ 10'h020);
        put_line(20, 2);
        ne = 0;
        put_ref(1'b1, 1'b1, 1'b1);
        play();
        chk(nerr == 1, "R6 error pulse", nerr, 1);
        chk(nl == 0, "R6 no line after bad status", nl, 0);
        chk(ref_field && ref_vblank && ref_eav, "R6 flags kept", {ref_field, ref_vblank, ref_eav}, 3'b111);
        clear_all();
        put(10'h3FF); put(10'h000); put(10'h000); put(mk_xy(1'b0, 1'b0, 1'b0) & 10'h1FF);
        play();
        chk(nerr == 1 && nr == 0, "R6 marker bit clear", nerr, 1);
    endtask

    task automatic t_realign();
        // R9: damaged line, next start reference restores order
        clear_all();
        cfg_dual_edge = 1'b0;
        put_ref(1'b0, 1'b0, 1'b0);
        put(10'h111); put(10'h122); put(10'h133);
        expect_pix(10'h122, 10'h111, 1'b0);
        put_ref(1'b0, 1'b0, 1'b1);
        put_ref(1'b0, 1'b0, 1'b0);
        put_line(32, 2);
        put_ref(1'b0, 1'b0, 1'b1);
        play();
        compare_pixels("R9 realign after damaged line");
    endtask

    task automatic t_narrow();
        // R10: 8-bit input on upper bits
        clear_all();
        cfg_dual_edge = 1'b0; cfg_narrow = 1'b1;
        put(10'h3FC); put(10'h003); put(10'h001); put(mk_xy(1'b0, 1'b0, 1'b0) | 10'h003);
        put(10'h103); put(10'h043); put(10'h107); put(10'h047);
        put(10'h3FD); put(10'h002); put(10'h000); put(mk_xy(1'b0, 1'b0, 1'b1));
        expect_pix(10'h040, 10'h100, 1'b0);
        expect_pix(10'h044, 10'h104, 1'b1);
        play();
        compare_pixels("R10 narrow mode");
        chk(nr == 2, "R10 narrow references", nr, 2);
        cfg_narrow = 1'b0;
        play();
        chk(nl == 0 && nr == 0, "R10 3FC not saturated in 10-bit", nl + nr, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_dual_chroma_rise();
        t_dual_luma_rise();
        t_single();
        t_parity();
        t_realign();
        t_narrow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule